// File: doc/BRIEF.md
# PWM Event-Trigger Pulse Prescaler

This block sits beside a PWM timebase. It turns one of several timebase comparison strobes into a one-cycle trigger pulse for downstream consumers such as DMA channels or a converter start input. A 3-bit source code picks one of six strobes: counter at zero, counter at period, and up-counting or down-counting matches against compare A and compare B. A 2-bit prescale counter counts the selected strobes. A 2-bit period value sets how many strobes make one trigger.

An enable bit gates the trigger. While the block is disabled, strobes still advance the counter. The counter stops at the period value, so a trigger is left pending. A sticky flag records that a trigger was produced. Software clears the flag with a write-one acknowledge, and that write leaves the counter alone. Only a write to the period register returns the counter to zero.

To re-enable without firing on stale events, software first rewrites the period and then sets the enable bit. If the enable bit is set without that rewrite, any pending count fires at once. Every write and every strobe is sampled on one clock edge. The outputs are registered and change in the cycle after that edge.

Top module: `et_trig_prescaler`

## Requirements
- R1: A synchronous active-high reset clears the source code, enable, period, counter, flag and trigger output to 0.
- R2: Source codes map to strobes as follows: 1 zero match, 2 period match, 4 compare-A up, 5 compare-A down, 6 compare-B up, 7 compare-B down. Codes 0 and 3 select no strobe, so no strobe moves the counter.
- R3: The counter rises by one on each clock edge where the selected strobe is high. Strobes that are not selected have no effect.
- R4: With period N in 1..3 and enable 1, the edge that brings the count to N makes trig_o high for the next cycle and returns cnt_o to 0. Period 0 never produces a trigger, and the counter stays at 0.
- R5: A write to address 1 loads the period from data bits [1:0] and clears the counter, even when the value is unchanged. In that cycle the write wins over a strobe arriving in the same cycle, and no trigger fires.
- R6: With enable 0, selected strobes still advance the counter, which holds at the period value. No trigger and no flag are produced.
- R7: If enable is set while the count equals a non-zero period, a trigger fires on the first edge after the enable takes effect, with no new strobe needed.
- R8: Rewriting the period to 1 and then setting enable leaves no pending trigger. The next selected strobe fires.
- R9: The flag is set together with each trigger. A write to address 2 with data bit 0 set clears the flag and leaves the counter unchanged.
- R10: If a flag-clear write and a trigger fall in the same cycle, the flag ends up set.
- R11: A write to address 0 loads the source code from data bits [2:0] and enable from bit 3. A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 period, 2 acknowledge, 3 unused |
| wr_data_i | input | DATA_W (4) | Write data |
| ev_zero_i | input | 1 | Timebase counter equals zero |
| ev_prd_i | input | 1 | Timebase counter equals period |
| ev_upa_i | input | 1 | Counter equals compare A while counting up |
| ev_dna_i | input | 1 | Counter equals compare A while counting down |
| ev_upb_i | input | 1 | Counter equals compare B while counting up |
| ev_dnb_i | input | 1 | Counter equals compare B while counting down |
| trig_o | output | 1 | One-cycle trigger pulse |
| flag_o | output | 1 | Sticky trigger flag |
| cnt_o | output | 2 | Prescale counter value |
| sel_o | output | 3 | Current source code |
| en_o | output | 1 | Current enable bit |
| prd_o | output | 2 | Current period value |

## Verification
The hardest state to reach is a saturated count left behind while the block was disabled, combined with the two ways out of it. Setting enable alone must fire without a strobe. Rewriting the period first must cancel the pending trigger. Directed sequences build that state by disabling the block, sending extra strobes and then following each re-enable order. They also line up a flag-clear write with the edge that completes a period, and a period write with a strobe in the same cycle. A long seeded random phase then mixes writes to all four addresses with random strobe patterns. A bench model derived from the requirements checks every output after each step.

// File: rtl/et_pkg.sv
package et_pkg;

    localparam int CNT_W  = 2;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;
    localparam int NUM_EV = 6;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF0 = 3'd0,
        SRC_ZERO = 3'd1,
        SRC_PRD  = 3'd2,
        SRC_OFF3 = 3'd3,
        SRC_UPA  = 3'd4,
        SRC_DNA  = 3'd5,
        SRC_UPB  = 3'd6,
        SRC_DNB  = 3'd7
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTL = 2'd0,
        REG_PER = 2'd1,
        REG_ACK = 2'd2,
        REG_RSV = 2'd3
    } reg_e;

    typedef struct packed {
        logic dnb;
        logic upb;
        logic dna;
        logic upa;
        logic prd;
        logic zero;
    } strobes_s;

    typedef struct packed {
        src_e             src;
        logic             en;
        logic [CNT_W-1:0] per;
    } cfg_s;

    typedef struct packed {
        logic per_wr;
        logic ack;
    } cmd_s;

    function automatic logic pick_strobe(input src_e src, input strobes_s s);
        logic hit;
        case (src)
            SRC_ZERO: hit = s.zero;
            SRC_PRD:  hit = s.prd;
            SRC_UPA:  hit = s.upa;
            SRC_DNA:  hit = s.dna;
            SRC_UPB:  hit = s.upb;
            SRC_DNB:  hit = s.dnb;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [CNT_W-1:0] bump_sat(input logic [CNT_W-1:0] cnt,
                                                   input logic [CNT_W-1:0] lim);
        return (cnt < lim) ? cnt + 1'b1 : cnt;
    endfunction

endpackage

// File: rtl/et_regs.sv
module et_regs
    import et_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_s              cfg,
    output cmd_s              cmd
);
    localparam int EN_BIT = SEL_W;

    reg_e addr_q;
    cfg_s cfg_q;

    assign addr_q = reg_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr_q)
                REG_CTL: begin
                    cfg_q.src <= src_e'(wr_data[SEL_W-1:0]);
                    cfg_q.en  <= wr_data[EN_BIT];
                end
                REG_PER: cfg_q.per <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd.per_wr = wr_en && (addr_q == REG_PER);
        cmd.ack    = wr_en && (addr_q == REG_ACK) && wr_data[0];
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/et_evsel.sv
module et_evsel
    import et_pkg::*;
(
    input  src_e     src,
    input  strobes_s strobes,
    output logic     hit
);
    assign hit = pick_strobe(src, strobes);
endmodule

// File: rtl/et_prescale.sv
module et_prescale
    import et_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             en,
    input  logic [CNT_W-1:0] per,
    input  logic             per_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             trig,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_adv;
    logic             trig_q;

    always_comb begin
        cnt_adv = hit ? bump_sat(cnt_q, per) : cnt_q;
        fire    = !per_wr && en && (per != '0) && (cnt_adv == per);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= fire;
            if (per_wr || fire) cnt_q <= '0;
            else                cnt_q <= cnt_adv;
        end
    end

    assign cnt  = cnt_q;
    assign trig = trig_q;

endmodule

// File: rtl/et_flag.sv
module et_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (ack) flag <= 1'b0;
    end
endmodule

// File: rtl/et_trig_prescaler.sv
module et_trig_prescaler
    import et_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ev_zero_i,
    input  logic              ev_prd_i,
    input  logic              ev_upa_i,
    input  logic              ev_dna_i,
    input  logic              ev_upb_i,
    input  logic              ev_dnb_i,
    output logic              trig_o,
    output logic              flag_o,
    output logic [1:0]        cnt_o,
    output logic [2:0]        sel_o,
    output logic              en_o,
    output logic [1:0]        prd_o
);
    cfg_s     cfg;
    cmd_s     cmd;
    strobes_s strobes;
    logic     hit;
    logic     fire;

    always_comb begin
        strobes.zero = ev_zero_i;
        strobes.prd  = ev_prd_i;
        strobes.upa  = ev_upa_i;
        strobes.dna  = ev_dna_i;
        strobes.upb  = ev_upb_i;
        strobes.dnb  = ev_dnb_i;
    end

    et_regs #(.DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .cfg     (cfg),
        .cmd     (cmd)
    );

    et_evsel evsel_i (
        .src     (cfg.src),
        .strobes (strobes),
        .hit     (hit)
    );

    et_prescale prescale_i (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .en     (cfg.en),
        .per    (cfg.per),
        .per_wr (cmd.per_wr),
        .cnt    (cnt_o),
        .trig   (trig_o),
        .fire   (fire)
    );

    et_flag flag_i (
        .clk  (clk),
        .rst  (rst),
        .set  (fire),
        .ack  (cmd.ack),
        .flag (flag_o)
    );

    assign sel_o = cfg.src;
    assign en_o  = cfg.en;
    assign prd_o = cfg.per;

endmodule

// File: rtl/et_trig_prescaler_chk.sv
module et_trig_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [1:0] wr_addr_i,
    input logic       trig_o,
    input logic       flag_o,
    input logic [1:0] cnt_o,
    input logic       en_o,
    input logic [1:0] prd_o
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!trig_o && !flag_o && cnt_o == 2'd0 && !en_o && prd_o == 2'd0));

    p_zero_period_r4: assert property (@(posedge clk) disable iff (rst)
        (prd_o == 2'd0) |=> !trig_o);

    p_trig_restart_r4: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (cnt_o == 2'd0));

    p_period_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd1) |=> (cnt_o == 2'd0 && !trig_o));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !en_o |=> !trig_o);

    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= prd_o);

    p_flag_with_trig_r9: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> flag_o);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !(wr_en_i && wr_addr_i == 2'd2)) |=> flag_o);
endmodule

bind et_trig_prescaler et_trig_prescaler_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .trig_o    (trig_o),
    .flag_o    (flag_o),
    .cnt_o     (cnt_o),
    .en_o      (en_o),
    .prd_o     (prd_o)
);

// File: tb/et_trig_prescaler_tb.sv
`timescale 1ns/1ps
module et_trig_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = 2'd0;
    logic [3:0] wr_data_i = 4'd0;
    logic [5:0] ev = 6'd0;
    logic       trig_o, flag_o, en_o;
    logic [1:0] cnt_o, prd_o;
    logic [2:0] sel_o;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic [2:0] m_sel;
    logic       m_en, m_flag, m_trig;
    logic [1:0] m_prd, m_cnt;

    always #2.5 clk = ~clk;

    et_trig_prescaler dut_i (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .ev_zero_i(ev[0]), .ev_prd_i(ev[1]), .ev_upa_i(ev[2]),
        .ev_dna_i(ev[3]), .ev_upb_i(ev[4]), .ev_dnb_i(ev[5]),
        .trig_o(trig_o), .flag_o(flag_o), .cnt_o(cnt_o),
        .sel_o(sel_o), .en_o(en_o), .prd_o(prd_o)
    );

    // R2 code map: 1 zero(ev0), 2 period(ev1), 4 upA(ev2), 5 dnA(ev3), 6 upB(ev4), 7 dnB(ev5)
    function automatic logic exp_hit(input logic [2:0] code, input logic [5:0] e);
        case (code)
            3'd1: return e[0];
            3'd2: return e[1];
            3'd4: return e[2];
            3'd5: return e[3];
            3'd6: return e[4];
            3'd7: return e[5];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic w, input logic [1:0] a,
                              input logic [3:0] d, input logic [5:0] e);
        logic [1:0] adv;
        logic       f;
        logic       pw;
        pw  = w && (a == 2'd1);
        adv = exp_hit(m_sel, e) ? ((m_cnt < m_prd) ? m_cnt + 2'd1 : m_cnt) : m_cnt;
        f   = !pw && m_en && (m_prd != 2'd0) && (adv == m_prd);
        m_trig = f;
        m_cnt  = (pw || f) ? 2'd0 : adv;
        if (f) m_flag = 1'b1;
        else if (w && a == 2'd2 && d[0]) m_flag = 1'b0;
        if (w && a == 2'd0) begin m_sel = d[2:0]; m_en = d[3]; end
        if (pw) m_prd = d[1:0];
    endtask

    task automatic step(input string tag, input logic w, input logic [1:0] a,
                        input logic [3:0] d, input logic [5:0] e);
        wr_en_i = w; wr_addr_i = a; wr_data_i = d; ev = e;
        @(posedge clk);
        model_edge(w, a, d, e);
        @(negedge clk);
        wr_en_i = 1'b0; ev = 6'd0;
        chk({tag, " trig"}, int'(trig_o), int'(m_trig));
        chk({tag, " flag"}, int'(flag_o), int'(m_flag));
        chk({tag, " cnt"},  int'(cnt_o),  int'(m_cnt));
        chk({tag, " cfg"},  int'({sel_o, en_o, prd_o}), int'({m_sel, m_en, m_prd}));
    endtask

    task automatic wr_ctl(input string tag, input logic [2:0] s, input logic e);
        step(tag, 1'b1, 2'd0, {e, s}, 6'd0);
    endtask
    task automatic wr_per(input string tag, input logic [1:0] p);
        step(tag, 1'b1, 2'd1, {2'b00, p}, 6'd0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sel = 0; m_en = 0; m_flag = 0; m_trig = 0; m_prd = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 trig", int'(trig_o), 0);
        chk("R1 flag", int'(flag_o), 0);
        chk("R1 cnt",  int'(cnt_o), 0);
        chk("R1 cfg",  int'({sel_o, en_o, prd_o}), 0);

        // R2 source map incl. reserved codes
        for (int c = 0; c < 8; c++) begin
            wr_ctl("R2", c[2:0], 1'b0);
            wr_per("R2", 2'd3);
            step("R2", 1'b0, 2'd0, 4'd0, 6'h3F);
            chk("R2 code cnt", int'(cnt_o), (c == 0 || c == 3) ? 0 : 1);
        end

        // R3 unselected strobes ignored
        wr_ctl("R3", 3'd4, 1'b0);
        wr_per("R3", 2'd3);
        step("R3", 1'b0, 2'd0, 4'd0, 6'b111011);
        chk("R3 unselected cnt", int'(cnt_o), 0);
        step("R3", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R3 selected cnt", int'(cnt_o), 1);

        // R4 period 3 enabled
        wr_ctl("R4", 3'd4, 1'b1);
        wr_per("R4", 2'd3);
        step("R4", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R4", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R4 no early trig", int'(trig_o), 0);
        step("R4", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R4 trig on third", int'(trig_o), 1);
        chk("R4 cnt restart", int'(cnt_o), 0);
        step("R4", 1'b0, 2'd0, 4'd0, 6'd0);
        chk("R4 single pulse", int'(trig_o), 0);

        // R5 same-value period write beats strobe
        step("R5", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R5", 1'b1, 2'd1, 4'd3, 6'b000100);
        chk("R5 cnt cleared", int'(cnt_o), 0);
        chk("R5 no trig", int'(trig_o), 0);
        wr_per("R4", 2'd0);
        for (int i = 0; i < 5; i++) step("R4", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R4 period0 cnt", int'(cnt_o), 0);
        chk("R4 period0 trig", int'(trig_o), 0);

        // R6 disabled counting with saturation
        step("R9", 1'b1, 2'd2, 4'd1, 6'd0);
        wr_ctl("R6", 3'd4, 1'b0);
        wr_per("R6", 2'd1);
        step("R6", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R6", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R6 saturated cnt", int'(cnt_o), 1);
        chk("R6 no trig", int'(trig_o), 0);
        chk("R6 no flag", int'(flag_o), 0);
        // R7 pending fires after enable without strobe
        wr_ctl("R7", 3'd4, 1'b1);
        chk("R7 not yet", int'(trig_o), 0);
        step("R7", 1'b0, 2'd0, 4'd0, 6'd0);
        chk("R7 pending trig", int'(trig_o), 1);
        chk("R7 flag", int'(flag_o), 1);

        // R8 rewrite period then enable
        wr_ctl("R8", 3'd4, 1'b0);
        step("R8", 1'b0, 2'd0, 4'd0, 6'b000100);
        wr_per("R8", 2'd1);
        wr_ctl("R8", 3'd4, 1'b1);
        step("R8", 1'b0, 2'd0, 4'd0, 6'd0);
        chk("R8 no stale trig", int'(trig_o), 0);
        step("R8", 1'b0, 2'd0, 4'd0, 6'b000100);
        chk("R8 next strobe trig", int'(trig_o), 1);

        // R9 clear keeps counter
        wr_per("R9", 2'd3);
        step("R9", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R9", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R9", 1'b1, 2'd2, 4'd1, 6'd0);
        chk("R9 flag cleared", int'(flag_o), 0);
        chk("R9 cnt kept", int'(cnt_o), 2);

        // R10 clear and trigger same cycle
        step("R10", 1'b1, 2'd2, 4'd1, 6'b000100);
        chk("R10 trig", int'(trig_o), 1);
        chk("R10 flag set wins", int'(flag_o), 1);

        // R11 address 3 write ignored
        step("R11", 1'b0, 2'd0, 4'd0, 6'b000100);
        step("R11", 1'b1, 2'd3, 4'hF, 6'd0);
        chk("R11 cfg", int'({sel_o, en_o, prd_o}), int'({3'd4, 1'b1, 2'd3}));
        chk("R11 cnt", int'(cnt_o), 1);
        chk("R11 flag", int'(flag_o), 1);

        // random mix, model-checked (R3)
        for (int i = 0; i < 4000; i++) begin
            logic       w;
            logic [1:0] a;
            logic [3:0] d;
            logic [5:0] e;
            w = ($urandom_range(0, 3) == 0);
            a = 2'($urandom_range(0, 3));
            d = 4'($urandom_range(0, 15));
            if (a == 2'd0 && $urandom_range(0, 3) != 0) d[3] = 1'b1;
            e = 6'($urandom_range(0, 63)) & 6'($urandom_range(0, 63));
            step("R3 random", w, a, d, e);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule